// File: doc/BRIEF.md
# Tag-Based Memory Write Region Guard

This block polices memory writes by the identity of the requester. Every write request carries an address and a 6-bit requester tag. The block compares the address against a set of programmable windows. Each window has an inclusive lower bound, an inclusive upper bound and a 64-bit mask with one enable bit per tag. The block also holds a global 64-bit tag-enable mask that sits above all windows. A write is accepted only when the global mask allows its tag and at least one window both contains the address and enables the tag. Any other write gets an access-error response.

The guard only reports. It never holds, delays or changes data, and read requests pass through without checks. A small write-only configuration port programs the bounds and masks. That port takes effect only while the privilege input is high. A write attempted without privilege changes nothing and raises a sticky error flag. The response is a registered grant or error pulse that appears one clock after the request.

Configuration address layout (6 bits with the default parameters): bits [2:0] select the window, bits [4:3] select the field (0 lower bound, 1 upper bound, 2 tag enables for tags 0 to 31, 3 tag enables for tags 32 to 63), and bit 5 selects the global mask. With bit 5 set, only fields 2 and 3 with window bits zero are used (addresses 48 and 56); every other combination is ignored. In an enable word, bit n belongs to tag n (low word) or tag 32+n (high word).

Top module: `wr_region_guard`

## Requirements
- R1: After reset, resp_grant, resp_err and cfg_err are low, all window bounds and window enable masks are zero, and every write to any address is answered with an error.
- R2: A write is granted when lower <= address <= upper for at least one window whose enable bit for the request tag is set, and the global enable bit for that tag is set. Both bounds are inclusive. Tags 0 to 31 use enable word field 2, bit = tag; tags 32 to 63 use field 3, bit = tag - 32.
- R3: A write that does not meet R2 is answered with resp_err high and resp_grant low.
- R4: The response to a request sampled at clock edge k is a single-cycle pulse after edge k. Exactly one of resp_grant and resp_err is high then, and both are low in any cycle that follows an edge with no valid request.
- R5: A valid request with req_write low is always granted, whatever its address and tag.
- R6: A configuration write with cfg_priv low changes no bound or mask and sets cfg_err. cfg_err stays high until reset.
- R7: A window whose lower bound is greater than its upper bound matches no address.
- R8: The global tag-enable words (address 48 for tags 0 to 31, address 56 for tags 32 to 63) reset to all ones. A cleared global bit denies every write from that tag, even inside an enabled window.
- R9: Windows are independent. A write denied by one window is granted when another window covers the address with the tag enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 = write (checked), 0 = read (passed) |
| req_addr | input | 32 | Request address |
| req_tag | input | 6 | Requester tag |
| resp_grant | output | 1 | Registered grant pulse |
| resp_err | output | 1 | Registered access-error pulse |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_priv | input | 1 | Privilege qualifier for configuration writes |
| cfg_addr | input | 6 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_err | output | 1 | Sticky flag for unprivileged configuration writes |

## Verification
The hardest case to reach from the ports is a silent rejection. An unprivileged write to a mask must leave the mask unchanged, and nothing can read the mask back. The stimulus therefore aims that write at an enable word that a known tag depends on. It then shows that the same tag is still granted in that window. The word split is handled the same way: tags 3 and 35 share a bit position in different words, and both are probed in one window where only one of them is enabled. Inverted windows, bound edges and overlapping windows are reached by programming several windows with chosen masks before a vector table is replayed.

// File: rtl/wr_region_guard_pkg.sv
package wr_region_guard_pkg;

   // Field selector values inside a configuration address.
   localparam int FLD_LOWER  = 0;
   localparam int FLD_UPPER  = 1;
   localparam int FLD_MASK0  = 2;   // first tag-enable word, further words follow

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   function automatic int fld_width(input int words);
      return $clog2(FLD_MASK0 + words);
   endfunction

endpackage

// File: rtl/wr_region_guard_cfg.sv
module wr_region_guard_cfg #(
   parameter int N_REGION = 8,
   parameter int NWORDS   = 2,
   parameter int RIDX_W   = 3,
   parameter int FLD_W    = 2,
   parameter int CA_W     = 6
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cfg_we,
   input  logic                       cfg_priv,
   input  logic [CA_W-1:0]            cfg_addr,
   output logic [N_REGION-1:0]        lo_we,
   output logic [N_REGION-1:0]        hi_we,
   output logic [N_REGION*NWORDS-1:0] mask_we,
   output logic [NWORDS-1:0]          glb_we,
   output logic                       cfg_err
);
   import wr_region_guard_pkg::*;

   if (CA_W != 1 + FLD_W + RIDX_W) begin : g_bad_ca
      $error("cfg address width does not match its fields");
   end
   if ((1 << FLD_W) < FLD_MASK0 + NWORDS) begin : g_bad_fld
      $error("field selector too narrow for the enable words");
   end

   logic [RIDX_W-1:0] sel_reg;
   logic [FLD_W-1:0]  sel_fld;
   logic              sel_glb;
   logic              wr_ok;
   logic              err_q;

   assign sel_reg = cfg_addr[RIDX_W-1:0];
   assign sel_fld = cfg_addr[RIDX_W +: FLD_W];
   assign sel_glb = cfg_addr[CA_W-1];
   assign wr_ok   = cfg_we & cfg_priv;

   for (genvar r = 0; r < N_REGION; r++) begin : g_reg
      logic hit_r;
      assign hit_r    = wr_ok & ~sel_glb & (sel_reg == RIDX_W'(r));
      assign lo_we[r] = hit_r & (sel_fld == FLD_W'(FLD_LOWER));
      assign hi_we[r] = hit_r & (sel_fld == FLD_W'(FLD_UPPER));
      for (genvar w = 0; w < NWORDS; w++) begin : g_word
         assign mask_we[r*NWORDS + w] = hit_r & (sel_fld == FLD_W'(FLD_MASK0 + w));
      end
   end

   for (genvar w = 0; w < NWORDS; w++) begin : g_glb
      assign glb_we[w] = wr_ok & sel_glb & (sel_reg == '0) &
                         (sel_fld == FLD_W'(FLD_MASK0 + w));
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                  err_q <= 1'b0;
      else if (cfg_we && !cfg_priv) err_q <= 1'b1;
   end
   assign cfg_err = err_q;

   // R6: an unprivileged write raises the flag and the flag never drops.
   a_r6_err_set: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !cfg_priv) |=> cfg_err);
   a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |=> cfg_err);
   // R6: no strobe leaves the decoder without privilege.
   a_r6_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_priv |-> (lo_we == '0 && hi_we == '0 && mask_we == '0 && glb_we == '0));

endmodule

// File: rtl/wr_region_guard_window.sv
module wr_region_guard_window #(
   parameter int ADDR_W = 32,
   parameter int TAG_W  = 6,
   parameter int CFG_DW = 32,
   parameter int NWORDS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lo_we,
   input  logic              hi_we,
   input  logic [NWORDS-1:0] mask_we,
   input  logic [CFG_DW-1:0] wdata,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [TAG_W-1:0]  req_tag,
   output logic              hit
);
   localparam int NTAGS = 1 << TAG_W;

   if (ADDR_W > CFG_DW) begin : g_bad_aw
      $error("address wider than configuration data");
   end
   if (NTAGS != NWORDS * CFG_DW) begin : g_bad_nw
      $error("enable words do not cover all tags");
   end

   logic [ADDR_W-1:0] bound_d;
   logic [ADDR_W-1:0] lo_q, hi_q;
   logic [NTAGS-1:0]  mask_q;
   logic              in_range;

   // Bound load width follows the address width.
   if (ADDR_W == CFG_DW) begin : g_full
      assign bound_d = wdata;
   end else begin : g_trunc
      assign bound_d = wdata[ADDR_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q   <= '0;
         hi_q   <= '0;
         mask_q <= '0;
      end else begin
         if (lo_we) lo_q <= bound_d;
         if (hi_we) hi_q <= bound_d;
         for (int w = 0; w < NWORDS; w++) begin
            if (mask_we[w]) mask_q[w*CFG_DW +: CFG_DW] <= wdata;
         end
      end
   end

   assign in_range = (req_addr >= lo_q) && (req_addr <= hi_q);
   assign hit      = in_range & mask_q[req_tag];

   // R6: state only moves when the decoder strobes it.
   a_r6_lo_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !lo_we |=> $stable(lo_q));
   a_r6_hi_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !hi_we |=> $stable(hi_q));
   a_r6_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_we == '0) |=> $stable(mask_q));

endmodule

// File: rtl/wr_region_guard_gate.sv
module wr_region_guard_gate #(
   parameter int TAG_W  = 6,
   parameter int CFG_DW = 32,
   parameter int NWORDS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NWORDS-1:0] glb_we,
   input  logic [CFG_DW-1:0] wdata,
   input  logic [TAG_W-1:0]  req_tag,
   output logic              allow
);
   localparam int NTAGS = 1 << TAG_W;

   logic [NTAGS-1:0] en_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q <= '1;
      end else begin
         for (int w = 0; w < NWORDS; w++) begin
            if (glb_we[w]) en_q[w*CFG_DW +: CFG_DW] <= wdata;
         end
      end
   end

   assign allow = en_q[req_tag];

   // R8: the global words only change on their own strobe.
   a_r8_glb_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (glb_we == '0) |=> $stable(en_q));

endmodule

// File: rtl/wr_region_guard.sv
module wr_region_guard
   import wr_region_guard_pkg::*;
#(
   parameter  int N_REGION = 8,
   parameter  int ADDR_W   = 32,
   parameter  int TAG_W    = 6,
   parameter  int CFG_DW   = 32,
   localparam int NTAGS    = 1 << TAG_W,
   localparam int NWORDS   = NTAGS / CFG_DW,
   localparam int RIDX_W   = idx_width(N_REGION),
   localparam int FLD_W    = fld_width(NWORDS),
   localparam int CA_W     = 1 + FLD_W + RIDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [TAG_W-1:0]  req_tag,
   output logic              resp_grant,
   output logic              resp_err,
   input  logic              cfg_we,
   input  logic              cfg_priv,
   input  logic [CA_W-1:0]   cfg_addr,
   input  logic [CFG_DW-1:0] cfg_wdata,
   output logic              cfg_err
);

   if (N_REGION < 1 || N_REGION > (1 << RIDX_W)) begin : g_bad_nr
      $error("region count out of range");
   end
   if (NWORDS < 1 || (NTAGS % CFG_DW) != 0) begin : g_bad_words
      $error("tag space must be a whole number of enable words");
   end

   logic [N_REGION-1:0]        lo_we, hi_we, win_hit;
   logic [N_REGION*NWORDS-1:0] mask_we;
   logic [NWORDS-1:0]          glb_we;
   logic                       tag_allow, write_ok;
   logic                       grant_q, err_q;

   wr_region_guard_cfg #(
      .N_REGION(N_REGION), .NWORDS(NWORDS), .RIDX_W(RIDX_W),
      .FLD_W(FLD_W), .CA_W(CA_W)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_priv(cfg_priv),
      .cfg_addr(cfg_addr), .lo_we(lo_we), .hi_we(hi_we),
      .mask_we(mask_we), .glb_we(glb_we), .cfg_err(cfg_err)
   );

   for (genvar r = 0; r < N_REGION; r++) begin : g_win
      wr_region_guard_window #(
         .ADDR_W(ADDR_W), .TAG_W(TAG_W), .CFG_DW(CFG_DW), .NWORDS(NWORDS)
      ) u_win (
         .clk(clk), .rst_n(rst_n),
         .lo_we(lo_we[r]), .hi_we(hi_we[r]),
         .mask_we(mask_we[r*NWORDS +: NWORDS]),
         .wdata(cfg_wdata), .req_addr(req_addr), .req_tag(req_tag),
         .hit(win_hit[r])
      );
   end

   wr_region_guard_gate #(
      .TAG_W(TAG_W), .CFG_DW(CFG_DW), .NWORDS(NWORDS)
   ) u_gate (
      .clk(clk), .rst_n(rst_n), .glb_we(glb_we), .wdata(cfg_wdata),
      .req_tag(req_tag), .allow(tag_allow)
   );

   assign write_ok = tag_allow & (|win_hit);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grant_q <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         grant_q <= req_valid & (~req_write | write_ok);
         err_q   <= req_valid & req_write & ~write_ok;
      end
   end

   assign resp_grant = grant_q;
   assign resp_err   = err_q;

   // R4: one response, one cycle later, and silence otherwise.
   a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(resp_grant && resp_err));
   a_r4_answer: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (resp_grant || resp_err));
   a_r4_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!resp_grant && !resp_err));
   // R5: reads are never refused.
   a_r5_read_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write) |=> resp_grant);
   // R8: a tag blocked globally is refused everywhere.
   a_r8_global_block: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && !tag_allow) |=> resp_err);
   // R3: no window hit means refusal.
   a_r3_no_window: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && win_hit == '0) |=> resp_err);

endmodule

// File: tb/wr_region_guard_test.sv
module wr_region_guard_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_write;
   logic [31:0] req_addr;
   logic [5:0]  req_tag;
   logic        resp_grant, resp_err;
   logic        cfg_we, cfg_priv;
   logic [5:0]  cfg_addr;
   logic [31:0] cfg_wdata;
   logic        cfg_err;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   wr_region_guard uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_tag(req_tag),
      .resp_grant(resp_grant), .resp_err(resp_err),
      .cfg_we(cfg_we), .cfg_priv(cfg_priv),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_err(cfg_err)
   );

   typedef struct packed {
      logic        wr;
      logic [31:0] addr;
      logic [5:0]  tag;
      logic        grant;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 32'h0000_1000, 6'd3,  1'b1},   // lower edge of window 0
      '{1'b1, 32'h0000_1FFF, 6'd3,  1'b1},   // upper edge of window 0
      '{1'b1, 32'h0000_0FFF, 6'd3,  1'b0},   // one below
      '{1'b1, 32'h0000_2000, 6'd3,  1'b0},   // one above
      '{1'b1, 32'h0000_1800, 6'd37, 1'b1},   // high enable word
      '{1'b1, 32'h0000_1800, 6'd5,  1'b0},   // tag not enabled
      '{1'b1, 32'h0000_1800, 6'd35, 1'b0},   // same bit, other word
      '{1'b1, 32'h0000_8050, 6'd20, 1'b1},   // window 1
      '{1'b1, 32'h0000_8050, 6'd40, 1'b0},   // window 1, high tag off
      '{1'b1, 32'h0000_4800, 6'd3,  1'b0},   // inside inverted window 2
      '{1'b1, 32'h0000_5000, 6'd0,  1'b0},   // inverted window bound
      '{1'b0, 32'h0000_0000, 6'd63, 1'b1},   // read passes
      '{1'b1, 32'h0000_80FF, 6'd3,  1'b1}    // window 1 upper edge
   };

   task automatic chk(input string what, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0b expected=%0b", what, act, exp);
      end
   endtask

   task automatic cfg_wr(input logic priv, input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_priv = priv; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0; cfg_priv = 1'b0;
   endtask

   task automatic req_chk(input string what, input logic wr, input logic [31:0] a,
                          input logic [5:0] t, input logic exp_g);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_tag = t;
      @(negedge clk);
      req_valid = 1'b0;
      chk({what, " grant"}, resp_grant, exp_g);
      chk({what, " err"},   resp_err,   ~exp_g);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      req_valid = 0; req_write = 0; req_addr = 0; req_tag = 0;
      cfg_we = 0; cfg_priv = 0; cfg_addr = 0; cfg_wdata = 0;
      do_reset();
      @(negedge clk);
      chk("R1 reset grant",   resp_grant, 1'b0);
      chk("R1 reset err",     resp_err,   1'b0);
      chk("R1 reset cfg_err", cfg_err,    1'b0);
      req_chk("R1 masks zero after reset", 1'b1, 32'h1000, 6'd3, 1'b0);

      // Window 0: 0x1000..0x1FFF, tags 3 and 37.
      cfg_wr(1'b1, 6'd0,  32'h0000_1000);
      cfg_wr(1'b1, 6'd8,  32'h0000_1FFF);
      cfg_wr(1'b1, 6'd16, 32'h0000_0008);
      cfg_wr(1'b1, 6'd24, 32'h0000_0020);
      // Window 1: 0x8000..0x80FF, tags 0..31.
      cfg_wr(1'b1, 6'd1,  32'h0000_8000);
      cfg_wr(1'b1, 6'd9,  32'h0000_80FF);
      cfg_wr(1'b1, 6'd17, 32'hFFFF_FFFF);
      // Window 2: inverted bounds, all tags (R7).
      cfg_wr(1'b1, 6'd2,  32'h0000_5000);
      cfg_wr(1'b1, 6'd10, 32'h0000_4000);
      cfg_wr(1'b1, 6'd18, 32'hFFFF_FFFF);
      cfg_wr(1'b1, 6'd26, 32'hFFFF_FFFF);
      chk("R6 privileged writes leave cfg_err low", cfg_err, 1'b0);

      for (int i = 0; i < NV; i++) begin
         req_chk($sformatf("vector %0d (R2 R3 R5 R7)", i),
                 VECS[i].wr, VECS[i].addr, VECS[i].tag, VECS[i].grant);
      end

      // R4: no request, no response.
      @(negedge clk);
      chk("R4 idle grant", resp_grant, 1'b0);
      chk("R4 idle err",   resp_err,   1'b0);

      // R9: window 3 covers everything for tag 8; window 0 alone refuses it.
      cfg_wr(1'b1, 6'd3,  32'h0000_0000);
      cfg_wr(1'b1, 6'd11, 32'hFFFF_FFFF);
      cfg_wr(1'b1, 6'd19, 32'h0000_0100);
      req_chk("R9 second window grants tag 8", 1'b1, 32'h1800, 6'd8, 1'b1);
      req_chk("R9 tag 9 still refused",        1'b1, 32'h1800, 6'd9, 1'b0);

      // R6: unprivileged clear of window 0 low word is dropped.
      cfg_wr(1'b0, 6'd16, 32'h0000_0000);
      chk("R6 cfg_err set", cfg_err, 1'b1);
      req_chk("R6 mask unchanged, tag 3 granted", 1'b1, 32'h1000, 6'd3, 1'b1);
      cfg_wr(1'b1, 6'd4, 32'h0000_0000);
      chk("R6 cfg_err sticky", cfg_err, 1'b1);

      // R8: global words gate tags.
      cfg_wr(1'b1, 6'd48, 32'hFFFF_FFF7);
      req_chk("R8 global clears tag 3",   1'b1, 32'h1000, 6'd3,  1'b0);
      req_chk("R8 tag 20 still allowed",  1'b1, 32'h8050, 6'd20, 1'b1);
      cfg_wr(1'b1, 6'd56, 32'hFFFF_FFDF);
      req_chk("R8 global clears tag 37",  1'b1, 32'h1800, 6'd37, 1'b0);

      // Reset again: flags, masks and global words return to reset values.
      do_reset();
      @(negedge clk);
      chk("R6 cfg_err cleared by reset", cfg_err, 1'b0);
      req_chk("R1 window masks cleared", 1'b1, 32'h8050, 6'd20, 1'b0);
      cfg_wr(1'b1, 6'd0,  32'h0000_1000);
      cfg_wr(1'b1, 6'd8,  32'h0000_1FFF);
      cfg_wr(1'b1, 6'd16, 32'h0000_0008);
      req_chk("R8 global tag 3 restored by reset", 1'b1, 32'h1000, 6'd3, 1'b1);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule